// File: doc/BRIEF.md
# Quad PSRAM Probe and Mode-Setup Controller

This block runs once after reset. It looks for up to two quad serial PSRAM devices that share one memory port, and it switches every device it finds into four-line mode. It does not toggle the serial pins itself. Instead it drives a small command interface towards a serial engine: a sequence index selects a preprogrammed command sequence, an address is supplied alongside it, and a one-cycle start launches the sequence. The engine answers with a done pulse and, for the identifier read, four bytes of read data.

At each candidate address the controller takes the device out of quad mode and resets it. It then reads its identifier and decodes a capacity in megabytes from vendor-specific identifier fields. A device that is found receives the enter-quad command. The next device is then probed at the address that directly follows the capacity found so far. Probing stops at the first empty slot.

When the controller has finished, it holds a sticky done flag. It also reports the size of each device and the total capacity in bytes. In quad mode the engine carries the runtime traffic on four lines: reads use command 0xEB with a 24-bit address and 6 dummy cycles, and writes use 0x38 with a 24-bit address. That traffic is outside this block.

Top module: `psram_probe_ctrl`

## Requirements
- R1: While reset is low, `cmd_start`, `probe_done`, `dev_sizes` and `total_bytes` are all zero. After reset is released, the first command is launched with sequence index 0 at address 0.
- R2: At each candidate address the commands come in this order: index 0 (exit quad, 0xF5 on four lines), index 1 (reset enable, 0x66 on one line), index 2 (reset, 0x99 on one line), index 3 (read ID: 0x9F on one line, 24 dummy cycles, then four bytes read on one line). All four use that same address.
- R3: `cmd_start` is high for exactly one cycle per command. No new command starts until `cmd_done` has answered the previous one. A `cmd_done` pulse with no command outstanding is ignored and causes no command and no change to any output.
- R4: When the identifier's bits 15:0 equal 0x5D0D, the device size is 8 MB. All other identifier bits are ignored.
- R5: When bits 15:0 equal 0x5D9D, the size is taken from bits 23:21: code 3'b011 gives 8 MB and code 3'b100 gives 16 MB.
- R6: Any other identifier, and any other size code under 0x5D9D, gives a size of 0 (no device).
- R7: When a device is found, it next receives index 4 (enter quad, 0x35 on one line) at its own address. The next device is then probed at the previous address plus that size times 2^20.
- R8: If the device at address 0 is absent, the controller finishes after its read ID, with no further command and all sizes zero.
- R9: A second device that is found receives index 4 at its address and the controller then finishes. A second device that is absent leaves its size at 0 and the controller finishes without index 4.
- R10: `dev_sizes[7:0]` holds the first device's size in MB and `dev_sizes[15:8]` holds the second's. `total_bytes` equals (size0 + size1) × 0x100000.
- R11: `probe_done` rises when probing ends and stays high until reset. No `cmd_start` occurs while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; restarts probing |
| cmd_seq | output | 3 | Sequence index of the current command |
| cmd_addr | output | ADDR_W (32) | Target address of the current command |
| cmd_start | output | 1 | One-cycle launch of the command |
| cmd_done | input | 1 | One-cycle completion from the serial engine |
| cmd_rdata | input | DATA_W (32) | Read data, valid with `cmd_done` |
| dev_sizes | output | NUM_DEV*SIZE_W (16) | Per-device size in MB, device 0 in the low byte |
| total_bytes | output | ADDR_W (32) | Total detected capacity in bytes |
| probe_done | output | 1 | Probing finished; sticky until reset |

## Verification
The assertions assume that the serial engine is well behaved. It pulses `cmd_done` for a single cycle, never in the same cycle as `cmd_start`, and presents valid `cmd_rdata` with it. Under those conditions the handshake and ordering properties hold. The bench's responder model keeps to this. It sees `cmd_start` on a falling edge, waits a per-vector latency of zero to three cycles, and then drives one done pulse on a falling edge. It returns one identifier for address 0 and another for every other address. The only stray pulse is injected on purpose, with nothing outstanding, after probing has finished.

// File: rtl/psram_probe_pkg.sv
package psram_probe_pkg;

   // Sequence indices understood by the serial engine (encoding is behaviour)
   typedef enum logic [2:0] {
      SEQ_EXIT_QUAD  = 3'd0,
      SEQ_RST_EN     = 3'd1,
      SEQ_RST        = 3'd2,
      SEQ_READ_ID    = 3'd3,
      SEQ_ENTER_QUAD = 3'd4
   } seq_idx_e;

   typedef enum logic [1:0] {
      PH_LAUNCH = 2'd0,
      PH_WAIT   = 2'd1,
      PH_FIN    = 2'd2
   } phase_e;

   localparam logic [15:0] ID_KEY_PLAIN = 16'h5D0D;
   localparam logic [15:0] ID_KEY_CODED = 16'h5D9D;
   localparam logic [2:0]  CODE_8MB     = 3'b011;
   localparam logic [2:0]  CODE_16MB    = 3'b100;

endpackage

// File: rtl/psram_id_decode.sv
module psram_id_decode #(
   parameter int DATA_W = 32,
   parameter int SIZE_W = 8
) (
   input  logic [DATA_W-1:0] id_word,
   output logic [SIZE_W-1:0] size_mb
);
   import psram_probe_pkg::*;

   generate
      if (DATA_W < 24) begin : g_bad_data_w
         $error("psram_id_decode: DATA_W must cover the size-code field");
      end
      if (SIZE_W < 5) begin : g_bad_size_w
         $error("psram_id_decode: SIZE_W too narrow for 16 MB");
      end
   endgenerate

   logic [2:0] size_code;
   assign size_code = id_word[23:21];

   always_comb begin
      size_mb = '0;
      if (id_word[15:0] == ID_KEY_PLAIN) begin
         size_mb = SIZE_W'(8);
      end else if (id_word[15:0] == ID_KEY_CODED) begin
         case (size_code)
            CODE_8MB:  size_mb = SIZE_W'(8);
            CODE_16MB: size_mb = SIZE_W'(16);
            default:   size_mb = '0;
         endcase
      end
   end

   // bits outside the decoded fields carry no meaning here
   logic unused_id_bits;
   assign unused_id_bits = ^{id_word[DATA_W-1:24], id_word[20:16]};

endmodule

// File: rtl/psram_cmd_handshake.sv
module psram_cmd_handshake #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         launch,
   input  psram_probe_pkg::seq_idx_e    seq_in,
   input  logic [ADDR_W-1:0]            addr_in,
   output logic [2:0]                   cmd_seq,
   output logic [ADDR_W-1:0]            cmd_addr,
   output logic                         cmd_start,
   input  logic                         cmd_done,
   input  logic [DATA_W-1:0]            cmd_rdata,
   output logic                         ack,
   output logic [DATA_W-1:0]            rdata
);
   import psram_probe_pkg::*;

   logic                busy_q;
   logic                start_q;
   logic                ack_q;
   seq_idx_e            seq_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         ack_q   <= 1'b0;
         seq_q   <= SEQ_EXIT_QUAD;
         addr_q  <= '0;
         rdata_q <= '0;
      end else begin
         start_q <= 1'b0;
         ack_q   <= 1'b0;
         if (!busy_q && launch) begin
            busy_q  <= 1'b1;
            start_q <= 1'b1;
            seq_q   <= seq_in;
            addr_q  <= addr_in;
         end else if (busy_q && !start_q && cmd_done) begin
            busy_q  <= 1'b0;
            ack_q   <= 1'b1;
            rdata_q <= cmd_rdata;
         end
      end
   end

   assign cmd_seq   = seq_q;
   assign cmd_addr  = addr_q;
   assign cmd_start = start_q;
   assign ack       = ack_q;
   assign rdata     = rdata_q;

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start); // R3
   AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !busy_q); // R3
   AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(cmd_done)); // R3

endmodule

// File: rtl/psram_probe_seq.sv
module psram_probe_seq #(
   parameter int ADDR_W   = 32,
   parameter int SIZE_W   = 8,
   parameter int MB_SHIFT = 20,
   parameter int NUM_DEV  = 2,
   localparam int SLOT_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
   localparam int TOT_W   = SIZE_W + SLOT_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ack,
   input  logic [SIZE_W-1:0]            found_size,
   output logic                         launch,
   output psram_probe_pkg::seq_idx_e    seq_out,
   output logic [ADDR_W-1:0]            addr_out,
   output logic [NUM_DEV*SIZE_W-1:0]    sizes_flat,
   output logic [TOT_W-1:0]             total_mb,
   output logic                         done
);
   import psram_probe_pkg::*;

   generate
      if (NUM_DEV < 1 || NUM_DEV > 8) begin : g_bad_num_dev
         $error("psram_probe_seq: NUM_DEV out of range");
      end
      if (ADDR_W < TOT_W + MB_SHIFT) begin : g_bad_addr_w
         $error("psram_probe_seq: ADDR_W cannot hold the total capacity");
      end
   endgenerate

   phase_e              phase_q;
   seq_idx_e            step_q;
   logic [SLOT_W-1:0]   slot_q;
   logic [ADDR_W-1:0]   base_q;
   logic [SIZE_W-1:0]   size_q [NUM_DEV];
   logic                last_slot;

   assign last_slot = (32'(slot_q) == NUM_DEV - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_LAUNCH;
         step_q  <= SEQ_EXIT_QUAD;
         slot_q  <= '0;
         base_q  <= '0;
         for (int i = 0; i < NUM_DEV; i++) size_q[i] <= '0;
      end else begin
         case (phase_q)
            PH_LAUNCH: phase_q <= PH_WAIT;
            PH_WAIT: if (ack) begin
               phase_q <= PH_LAUNCH;
               case (step_q)
                  SEQ_EXIT_QUAD: step_q <= SEQ_RST_EN;
                  SEQ_RST_EN:    step_q <= SEQ_RST;
                  SEQ_RST:       step_q <= SEQ_READ_ID;
                  SEQ_READ_ID: begin
                     size_q[slot_q] <= found_size;
                     if (found_size == '0) phase_q <= PH_FIN;
                     else                  step_q  <= SEQ_ENTER_QUAD;
                  end
                  SEQ_ENTER_QUAD: begin
                     if (last_slot) begin
                        phase_q <= PH_FIN;
                     end else begin
                        slot_q <= slot_q + SLOT_W'(1);
                        base_q <= base_q + (ADDR_W'(size_q[slot_q]) << MB_SHIFT);
                        step_q <= SEQ_EXIT_QUAD;
                     end
                  end
                  default: phase_q <= PH_FIN;
               endcase
            end
            default: phase_q <= PH_FIN;
         endcase
      end
   end

   assign launch   = (phase_q == PH_LAUNCH);
   assign seq_out  = step_q;
   assign addr_out = base_q;
   assign done     = (phase_q == PH_FIN);

   genvar g;
   generate
      for (g = 0; g < NUM_DEV; g++) begin : g_size_out
         assign sizes_flat[g*SIZE_W +: SIZE_W] = size_q[g];
      end
   endgenerate

   always_comb begin
      total_mb = '0;
      for (int i = 0; i < NUM_DEV; i++) total_mb = total_mb + TOT_W'(size_q[i]);
   end

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done); // R11
   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      ack && step_q == SEQ_READ_ID |=> (size_q[$past(slot_q)] == '0 ||
         size_q[$past(slot_q)] == SIZE_W'(8) || size_q[$past(slot_q)] == SIZE_W'(16))); // R6
   AST_SLOT_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q != '0 |-> size_q[slot_q - SLOT_W'(1)] != '0); // R9
   AST_EMPTY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      ack && step_q == SEQ_READ_ID && found_size == '0 |=> done); // R8

endmodule

// File: rtl/psram_probe_ctrl.sv
module psram_probe_ctrl #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SIZE_W   = 8,
   parameter int MB_SHIFT = 20,
   parameter int NUM_DEV  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   output logic [2:0]                 cmd_seq,
   output logic [ADDR_W-1:0]          cmd_addr,
   output logic                       cmd_start,
   input  logic                       cmd_done,
   input  logic [DATA_W-1:0]          cmd_rdata,
   output logic [NUM_DEV*SIZE_W-1:0]  dev_sizes,
   output logic [ADDR_W-1:0]          total_bytes,
   output logic                       probe_done
);
   import psram_probe_pkg::*;

   localparam int SLOT_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
   localparam int TOT_W  = SIZE_W + SLOT_W;

   logic                launch;
   seq_idx_e            seq_next;
   logic [ADDR_W-1:0]   addr_next;
   logic                ack;
   logic [DATA_W-1:0]   id_word;
   logic [SIZE_W-1:0]   found_size;
   logic [TOT_W-1:0]    total_mb;

   psram_cmd_handshake #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_handshake (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .seq_in    (seq_next),
      .addr_in   (addr_next),
      .cmd_seq   (cmd_seq),
      .cmd_addr  (cmd_addr),
      .cmd_start (cmd_start),
      .cmd_done  (cmd_done),
      .cmd_rdata (cmd_rdata),
      .ack       (ack),
      .rdata     (id_word)
   );

   psram_id_decode #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_decode (
      .id_word (id_word),
      .size_mb (found_size)
   );

   psram_probe_seq #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MB_SHIFT(MB_SHIFT), .NUM_DEV(NUM_DEV)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack        (ack),
      .found_size (found_size),
      .launch     (launch),
      .seq_out    (seq_next),
      .addr_out   (addr_next),
      .sizes_flat (dev_sizes),
      .total_mb   (total_mb),
      .done       (probe_done)
   );

   assign total_bytes = ADDR_W'(total_mb) << MB_SHIFT;

   AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      probe_done |-> !cmd_start); // R11
   AST_FAR_ADDR_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start && cmd_addr != '0 |-> dev_sizes[SIZE_W-1:0] != '0); // R7
   AST_ENTER_ONLY_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start && cmd_seq == 3'(SEQ_ENTER_QUAD) |-> total_bytes != '0); // R9

endmodule

// File: tb/test_psram_probe_ctrl.sv
module test_psram_probe_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd_seq;
   logic [31:0] cmd_addr;
   logic        cmd_start;
   logic        cmd_done;
   logic [31:0] cmd_rdata;
   logic [15:0] dev_sizes;
   logic [31:0] total_bytes;
   logic        probe_done;

   always #5 clk = ~clk;

   psram_probe_ctrl i_psram_probe_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_seq(cmd_seq), .cmd_addr(cmd_addr),
      .cmd_start(cmd_start), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
      .dev_sizes(dev_sizes), .total_bytes(total_bytes), .probe_done(probe_done)
   );

   typedef struct packed {
      logic [31:0] id0;
      logic [31:0] id1;
      logic [7:0]  s0;
      logic [7:0]  s1;
      logic [3:0]  lat;
   } vec_t;

   // R4 R5 R6 R7 R8 R9: identifier pairs and the sizes they must decode to
   localparam vec_t VECS [8] = '{
      '{32'h0000_5D0D, 32'h1234_5678, 8'd8,  8'd0,  4'd0},
      '{32'h0000_5D0D, 32'h0000_5D0D, 8'd8,  8'd8,  4'd2},
      '{32'h0060_5D9D, 32'h0080_5D9D, 8'd8,  8'd16, 4'd1},
      '{32'h0080_5D9D, 32'h0000_5D0D, 8'd16, 8'd8,  4'd0},
      '{32'h00A0_5D9D, 32'h0000_5D0D, 8'd0,  8'd0,  4'd1},
      '{32'hFFFF_5D0C, 32'h0000_5D0D, 8'd0,  8'd0,  4'd0},
      '{32'h0080_5D9D, 32'h0080_5D9D, 8'd16, 8'd16, 4'd3},
      '{32'hABCD_5D0D, 32'h00E0_5D9D, 8'd8,  8'd0,  4'd2}
   };

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   // responder model of the serial engine
   logic [31:0] cur_id0, cur_id1;
   int          cur_lat;
   bit          stray_req;
   bit          pending;
   int          wcnt;
   logic [31:0] p_addr;
   int          n_log;
   logic [2:0]  log_seq  [32];
   logic [31:0] log_addr [32];

   initial begin
      cmd_done = 0; cmd_rdata = '0; pending = 0; stray_req = 0; n_log = 0;
      wcnt = 0; p_addr = '0; cur_id0 = '0; cur_id1 = '0; cur_lat = 0;
      forever begin
         @(negedge clk);
         cmd_done = 0;
         if (stray_req) begin
            cmd_done = 1; cmd_rdata = 32'hDEAD_5D0D; stray_req = 0;
         end else if (pending) begin
            if (wcnt == 0) begin
               cmd_done  = 1;
               cmd_rdata = (p_addr == 0) ? cur_id0 : cur_id1;
               pending   = 0;
            end else begin
               wcnt--;
            end
         end
         if (rst_n && cmd_start) begin
            check(!pending, "R3 start while outstanding", 32'(pending), 0);
            if (n_log < 32) begin
               log_seq[n_log]  = cmd_seq;
               log_addr[n_log] = cmd_addr;
            end
            n_log++;
            pending = 1; wcnt = cur_lat; p_addr = cmd_addr;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "watchdog expired", 0, 1);
      finish_run();
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (3) @(negedge clk);
      pending = 0; n_log = 0;
      // R1: outputs cleared while in reset
      check(cmd_start == 0 && probe_done == 0, "R1 reset start/done",
            {30'd0, cmd_start, probe_done}, 0);
      check(dev_sizes == 0 && total_bytes == 0, "R1 reset sizes",
            {dev_sizes, total_bytes[15:0]}, 0);
      rst_n = 1;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!probe_done && t < 3000) begin
         @(negedge clk);
         t++;
      end
      check(probe_done, "R11 probe_done never rose", 32'(probe_done), 1);
   endtask

   initial begin
      logic [2:0]  exp_seq  [16];
      logic [31:0] exp_addr [16];
      int          ne;
      int          seen;
      logic [15:0] sizes_keep;

      for (int v = 0; v < 8; v++) begin
         cur_id0 = VECS[v].id0; cur_id1 = VECS[v].id1; cur_lat = int'(VECS[v].lat);
         do_reset();
         wait_done();
         ne = 0;
         for (int k = 0; k < 4; k++) begin
            exp_seq[ne] = 3'(k); exp_addr[ne] = 0; ne++;
         end
         if (VECS[v].s0 != 0) begin
            exp_seq[ne] = 3'd4; exp_addr[ne] = 0; ne++;
            for (int k = 0; k < 4; k++) begin
               exp_seq[ne] = 3'(k); exp_addr[ne] = 32'(VECS[v].s0) << 20; ne++;
            end
            if (VECS[v].s1 != 0) begin
               exp_seq[ne] = 3'd4; exp_addr[ne] = 32'(VECS[v].s0) << 20; ne++;
            end
         end
         check(n_log == ne, "R8/R9 command count", 32'(n_log), 32'(ne));
         for (int k = 0; k < ne && k < n_log; k++) begin
            check(log_seq[k] == exp_seq[k], "R2/R7 sequence index",
                  32'(log_seq[k]), 32'(exp_seq[k]));
            check(log_addr[k] == exp_addr[k], "R2/R7 command address",
                  log_addr[k], exp_addr[k]);
         end
         check(dev_sizes[7:0] == VECS[v].s0, "R4/R5/R6/R10 first size",
               32'(dev_sizes[7:0]), 32'(VECS[v].s0));
         check(dev_sizes[15:8] == VECS[v].s1, "R4/R5/R6/R10 second size",
               32'(dev_sizes[15:8]), 32'(VECS[v].s1));
         check(total_bytes == (32'(VECS[v].s0) + 32'(VECS[v].s1)) << 20, "R10 total bytes",
               total_bytes, (32'(VECS[v].s0) + 32'(VECS[v].s1)) << 20);
         seen = n_log;
         repeat (8) @(negedge clk);
         check(probe_done == 1 && n_log == seen, "R11 quiet and sticky after done",
               32'(n_log), 32'(seen));
      end

      // R3: stray done with nothing outstanding is ignored (last vector: 8 MB + 0)
      sizes_keep = dev_sizes;
      seen = n_log;
      stray_req = 1;
      repeat (4) @(negedge clk);
      check(n_log == seen, "R3 stray done launched a command", 32'(n_log), 32'(seen));
      check(dev_sizes == sizes_keep && probe_done, "R3 stray done changed outputs",
            32'(dev_sizes), 32'(sizes_keep));

      // R1: reset in the middle of probing restarts from index 0 at address 0
      cur_id0 = 32'h0000_5D0D; cur_id1 = 32'h0000_5D0D; cur_lat = 3;
      do_reset();
      repeat (12) @(negedge clk);
      do_reset();
      check(dev_sizes == 0 && probe_done == 0, "R1 mid-run reset cleared", 32'(dev_sizes), 0);
      repeat (3) @(negedge clk);
      check(n_log >= 1 && log_seq[0] == 3'd0 && log_addr[0] == 0, "R1 restart first command",
            {29'd0, log_seq[0]}, 0);
      wait_done();
      check(total_bytes == 32'h0100_0000, "R10 total after restart", total_bytes, 32'h0100_0000);

      finish_run();
   end

endmodule